// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block runs one integrating (dual-slope) analog-to-digital measurement cycle after another. It steps through a null phase, a fixed-length integrate phase and a de-integrate phase. The de-integrate phase can stretch into two extension phases when the external count accumulator keeps signalling that it has wrapped. From these phases it decodes four analog switch enables: input connect, null (auto-zero), positive reference and negative reference.

The comparator bit is read at the clock edge that ends the integrate phase. That bit is held as the polarity of the input, and it picks the reference that drives the integrator back toward zero. While de-integrating, the block compares the live comparator bit with the held polarity. The first mismatch is taken as the zero crossing, whichever way the comparator moves. The block then pulses zero-detect and stop, and returns to the null phase. If the accumulator strobe arrives three times with no crossing, the cycle is abandoned and an overflow flag is raised.

The null and integrate phase lengths are parameters counted in clocks. The number of steps in the de-integrate window is set by the external strobe.

Top module: `dual_slope_seq`

## Requirements
- R1: An active-low asynchronous reset puts the block in the null phase at once. During reset, `az_sw_o`=1 and `in_sw_o`, `ref_pos_sw_o`, `ref_neg_sw_o`, `pol_o`, `zero_det_o`, `rd_start_o`, `rd_stop_o` and `ovf_o` are all 0.
- R2: The null phase lasts AZ_LEN clocks with only `az_sw_o` high. It is followed by the integrate phase of RU_LEN clocks with only `in_sw_o` high, and then by de-integration.
- R3: `cnt_ext_i` and `cmp_i` have no effect during the null and integrate phases. The phase lengths and switch outputs stay as in R2.
- R4: `pol_o` takes the value of `cmp_i` at the clock edge that ends the integrate phase. It holds that value until the next such edge. `rd_start_o` is high for exactly the first de-integrate cycle.
- R5: In every de-integrate or extension cycle, exactly one reference enable is high: `ref_pos_sw_o` when `pol_o`=1, `ref_neg_sw_o` when `pol_o`=0. At most one of the four switch enables is ever high.
- R6: At any clock edge in de-integrate or either extension where `cmp_i` differs from `pol_o`, the block returns to the null phase. `zero_det_o` and `rd_stop_o` are then both high for that one following cycle.
- R7: A `cnt_ext_i` strobe in de-integrate moves the block to the first extension, and a second strobe moves it to the second extension. The reference enable stays on through both.
- R8: A `cnt_ext_i` strobe in the second extension with no zero crossing returns the block to the null phase. It pulses `rd_stop_o` without `zero_det_o` and sets `ovf_o`, which holds until the next `rd_start_o` cycle.
- R9: When a zero crossing and a `cnt_ext_i` strobe occur at the same edge, the zero crossing wins and no overflow is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion time base |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Comparator level, synchronous to clk_i |
| cnt_ext_i | input | 1 | Accumulator wrap strobe, one cycle |
| in_sw_o | output | 1 | Input amplifier connect enable |
| az_sw_o | output | 1 | Null (auto-zero) switch enable |
| ref_pos_sw_o | output | 1 | Positive reference enable |
| ref_neg_sw_o | output | 1 | Negative reference enable |
| pol_o | output | 1 | Held polarity (1 = comparator high at integrate end) |
| zero_det_o | output | 1 | One-cycle zero-crossing pulse |
| rd_start_o | output | 1 | One-cycle de-integrate start pulse |
| rd_stop_o | output | 1 | One-cycle de-integrate end pulse |
| ovf_o | output | 1 | Overflow flag of the last cycle |

## Verification
The main function is exercised with cycles in which the comparator is low at the end of integration and rises later, and with cycles in which it is high and falls. Together these show whether the polarity is held and whether the XOR crossing test works in both directions. Further cycles put the crossing inside the first and the second extension, or hold it back until the third strobe. These separate a working extension chain from one that stops early or never overflows. A crossing on the same edge as a strobe checks the priority. Strobes and comparator toggles during the null and integrate phases, and a reset in the middle of de-integration, test that those inputs are ignored and that the reset takes effect at once.

// File: rtl/ds_seq_pkg.sv
package ds_seq_pkg;
  typedef enum logic [2:0] {
    PH_AZ = 3'd0,
    PH_RU = 3'd1,
    PH_RD = 3'd2,
    PH_OR = 3'd3,
    PH_OF = 3'd4
  } phase_e;
endpackage

// File: rtl/ds_interval_ctr.sv
module ds_interval_ctr #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ds_zero_det.sv
module ds_zero_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic watch_i,
  input  logic cmp_i,
  output logic pol_o,
  output logic hit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pol_o <= 1'b0;
    else if (cap_i) pol_o <= cmp_i;
  end

  // mismatch against held polarity catches the return edge either way
  assign hit_o = watch_i & (cmp_i ^ pol_o);
endmodule

// File: rtl/ds_switch_dec.sv
module ds_switch_dec
  import ds_seq_pkg::*;
(
  input  phase_e ph_i,
  input  logic   pol_i,
  output logic   in_sw_o,
  output logic   az_sw_o,
  output logic   ref_pos_sw_o,
  output logic   ref_neg_sw_o
);
  logic deint;

  always_comb begin
    deint        = (ph_i == PH_RD) || (ph_i == PH_OR) || (ph_i == PH_OF);
    az_sw_o      = (ph_i == PH_AZ);
    in_sw_o      = (ph_i == PH_RU);
    ref_pos_sw_o = deint && pol_i;
    ref_neg_sw_o = deint && !pol_i;
  end
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import ds_seq_pkg::*;
#(
  parameter int AZ_LEN = 10000,
  parameter int RU_LEN = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_i,
  input  logic cnt_ext_i,
  output logic in_sw_o,
  output logic az_sw_o,
  output logic ref_pos_sw_o,
  output logic ref_neg_sw_o,
  output logic pol_o,
  output logic zero_det_o,
  output logic rd_start_o,
  output logic rd_stop_o,
  output logic ovf_o
);
  localparam int MAX_LEN = (AZ_LEN > RU_LEN) ? AZ_LEN : RU_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] AZ_LAST = CNT_W'(AZ_LEN - 1);
  localparam logic [CNT_W-1:0] RU_LAST = CNT_W'(RU_LEN - 1);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt;
  logic             timed, last, deint, hit, cap, expire;

  assign timed  = (ph_q == PH_AZ) || (ph_q == PH_RU);
  assign deint  = (ph_q == PH_RD) || (ph_q == PH_OR) || (ph_q == PH_OF);
  assign last   = ((ph_q == PH_AZ) && (cnt == AZ_LAST)) ||
                  ((ph_q == PH_RU) && (cnt == RU_LAST));
  assign cap    = (ph_q == PH_RU) && last;
  assign expire = (ph_q == PH_OF) && cnt_ext_i && !hit;

  ds_interval_ctr #(.W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (last || !timed),
    .cnt_o  (cnt)
  );

  ds_zero_det u_zd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .watch_i (deint),
    .cmp_i   (cmp_i),
    .pol_o   (pol_o),
    .hit_o   (hit)
  );

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_AZ: if (last) ph_d = PH_RU;
      PH_RU: if (last) ph_d = PH_RD;
      PH_RD: if (hit) ph_d = PH_AZ; else if (cnt_ext_i) ph_d = PH_OR;
      PH_OR: if (hit) ph_d = PH_AZ; else if (cnt_ext_i) ph_d = PH_OF;
      PH_OF: if (hit || cnt_ext_i) ph_d = PH_AZ;
      default: ph_d = PH_AZ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_AZ;
      zero_det_o <= 1'b0;
      rd_start_o <= 1'b0;
      rd_stop_o  <= 1'b0;
      ovf_o      <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      zero_det_o <= hit;
      rd_start_o <= cap;
      rd_stop_o  <= hit || expire;
      if (cap)         ovf_o <= 1'b0;
      else if (expire) ovf_o <= 1'b1;
    end
  end

  ds_switch_dec u_dec (
    .ph_i         (ph_q),
    .pol_i        (pol_o),
    .in_sw_o      (in_sw_o),
    .az_sw_o      (az_sw_o),
    .ref_pos_sw_o (ref_pos_sw_o),
    .ref_neg_sw_o (ref_neg_sw_o)
  );
endmodule

// File: rtl/ds_seq_chk.sv
module ds_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic in_sw,
  input logic az_sw,
  input logic rp_sw,
  input logic rn_sw,
  input logic pol,
  input logic zd,
  input logic start,
  input logic stop,
  input logic ovf
);
  p_reset_state_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (az_sw && !in_sw && !rp_sw && !rn_sw && !zd && !start && !stop && !ovf));

  p_runup_end_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_sw) |-> start);

  p_start_ref_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> (rp_sw || rn_sw));

  p_pol_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rp_sw || rn_sw) && !start) |-> $stable(pol));

  p_one_switch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({in_sw, az_sw, rp_sw, rn_sw}) == 1);

  p_ref_pol_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rp_sw || rn_sw) |-> (rp_sw == pol));

  p_zero_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zd |-> (az_sw && stop));

  p_ref_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rp_sw || rn_sw) |-> stop);

  p_ovf_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf) |-> (stop && !zd));
endmodule

bind dual_slope_seq ds_seq_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .in_sw  (in_sw_o),
  .az_sw  (az_sw_o),
  .rp_sw  (ref_pos_sw_o),
  .rn_sw  (ref_neg_sw_o),
  .pol    (pol_o),
  .zd     (zero_det_o),
  .start  (rd_start_o),
  .stop   (rd_stop_o),
  .ovf    (ovf_o)
);

// File: tb/dual_slope_seq_tb_top.sv
module dual_slope_seq_tb_top;
  localparam int AZ_N = 6;
  localparam int RU_N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp = 1'b0;
  logic ext = 1'b0;
  logic in_sw, az_sw, rp_sw, rn_sw, pol, zd, start, stop, ovf;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string scen = "R1 reset";

  always #10 clk = ~clk;

  dual_slope_seq #(.AZ_LEN(AZ_N), .RU_LEN(RU_N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp), .cnt_ext_i(ext),
    .in_sw_o(in_sw), .az_sw_o(az_sw), .ref_pos_sw_o(rp_sw), .ref_neg_sw_o(rn_sw),
    .pol_o(pol), .zero_det_o(zd), .rd_start_o(start), .rd_stop_o(stop), .ovf_o(ovf)
  );

  // reference model: phase 0 null, 1 integrate, 2 de-integrate, 3/4 extensions
  int m_ph = 0, m_t = 0;
  bit m_pol = 0, m_zd = 0, m_start = 0, m_stop = 0, m_ovf = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_t = 0; m_pol = 0; m_zd = 0; m_start = 0; m_stop = 0; m_ovf = 0;
    end else begin
      m_zd = 0; m_start = 0; m_stop = 0;
      if (m_ph == 0) begin
        if (m_t == AZ_N - 1) begin m_ph = 1; m_t = 0; end else m_t++;
      end else if (m_ph == 1) begin
        if (m_t == RU_N - 1) begin
          m_ph = 2; m_t = 0; m_pol = cmp; m_start = 1; m_ovf = 0;
        end else m_t++;
      end else if (cmp != m_pol) begin
        m_ph = 0; m_zd = 1; m_stop = 1;
      end else if (ext) begin
        if (m_ph == 4) begin m_ph = 0; m_stop = 1; m_ovf = 1; end
        else m_ph++;
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] act=%0b exp=%0b t=%0t", tag, scen, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 az_sw", az_sw, m_ph == 0);
    chk("R2 in_sw", in_sw, m_ph == 1);
    chk("R5 ref_pos", rp_sw, m_ph >= 2 && m_pol);
    chk("R5 ref_neg", rn_sw, m_ph >= 2 && !m_pol);
    chk("R4 pol", pol, m_pol);
    chk("R4 rd_start", start, m_start);
    chk("R6 zero_det", zd, m_zd);
    chk("R6 rd_stop", stop, m_stop);
    chk("R8 ovf", ovf, m_ovf);
  endtask

  task automatic step(input logic c, input logic e);
    @(negedge clk);
    compare_all();
    cmp = c;
    ext = e;
  endtask

  // run until de-integrate; wiggle exercises R3 (strobes and comparator ignored)
  task automatic to_rd(input logic c, input bit wiggle);
    int k = 0;
    while (m_ph != 2) begin
      logic e_ok;
      e_ok = (m_ph == 0) || (m_ph == 1 && m_t != RU_N - 1);
      if (wiggle && e_ok) step(k[0] ? ~c : c, k[0]);
      else step(c, 1'b0);
      k++;
    end
  endtask

  initial begin
    repeat (3) step(1'b0, 1'b1);
    chk("R1 az_sw", az_sw, 1'b1);
    chk("R1 refs", rp_sw | rn_sw | in_sw, 1'b0);
    chk("R1 pulses", zd | start | stop | ovf | pol, 1'b0);
    rst_n = 1'b1;

    scen = "R6 positive input rising";
    to_rd(1'b0, 1'b0);
    repeat (4) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    repeat (3) step(1'b1, 1'b0);

    scen = "R3 negative input falling, strobes ignored";
    to_rd(1'b1, 1'b1);
    repeat (3) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    repeat (3) step(1'b0, 1'b0);

    scen = "R7 crossing in first extension";
    to_rd(1'b0, 1'b0);
    step(1'b0, 1'b1);
    repeat (2) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    repeat (2) step(1'b1, 1'b0);

    scen = "R7 crossing in second extension";
    to_rd(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    repeat (2) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    repeat (2) step(1'b0, 1'b0);

    scen = "R8 overflow";
    to_rd(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    repeat (4) step(1'b1, 1'b0);
    chk("R8 ovf held", ovf, 1'b1);
    scen = "R8 ovf cleared at next start";
    to_rd(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    repeat (2) step(1'b1, 1'b0);

    scen = "R9 crossing beats strobe";
    to_rd(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    repeat (3) step(1'b1, 1'b0);

    scen = "R1 reset during de-integrate";
    to_rd(1'b1, 1'b0);
    step(1'b1, 1'b0);
    #3 rst_n = 1'b0;
    #1;
    chk("R1 az_sw async", az_sw, 1'b1);
    chk("R1 refs async", rp_sw | rn_sw | in_sw, 1'b0);
    chk("R1 pol async", pol, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    to_rd(1'b0, 1'b0);
    step(1'b1, 1'b0);
    repeat (2) step(1'b1, 1'b0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule